// File: doc/BRIEF.md
# Instruction ModR/M Field Decoder

The block receives an instruction one byte at a time and splits it into its parts. These parts are the opcode with its direction and width bits, the mode/register/operand byte, an optional scale-index-base byte, a displacement and an immediate. Each beat with `in_valid` high carries one byte. Beats with `in_valid` low are idle. When the final byte of an instruction has been taken, `done` pulses for one cycle. During that cycle every field output and the total byte count describe the instruction. The outputs keep those values until the opcode byte of the next instruction is taken.

The decoder accepts only a subset of two-operand instructions:

- A first byte of 0Fh is an escape. The following byte is the opcode, and no immediate comes after it.
- Any other first byte is a one-byte opcode, always followed by the mode byte.
- The opcodes of the form 100000sw are the only ones that carry an immediate.

The input `addr32` selects the 16-bit or 32-bit addressing rules. The input `opnd32` selects 16-bit or 32-bit full operand size. Both are sampled with the opcode byte.

The controller is a six-state machine:

- FETCH_OPC (`ST_OPC`) takes the first byte. It moves to `ST_OPC2` on 0Fh and to `ST_MODRM` on any other byte.
- `ST_OPC2` takes the escaped opcode and moves to `ST_MODRM`.
- `ST_MODRM` moves to one of four places: `ST_SIB` when an SIB byte is due, `ST_DISP` when displacement bytes are due, `ST_IMM` when immediate bytes are due, or back to `ST_OPC` with `done` when nothing is due.
- `ST_SIB` leaves to `ST_DISP`, `ST_IMM` or `ST_OPC`.
- `ST_DISP` stays until its last byte, then moves to `ST_IMM` or `ST_OPC`.
- `ST_IMM` stays until its last byte, then returns to `ST_OPC`.

Top module: `mrd_modrm_decoder`

## Requirements
- R1: After reset, `done` is low and `ins_len`, `disp_bytes` and `imm_bytes` read zero.
- R2: `wide_bit` shows bit 0 of the final opcode byte (0 = byte operand). `dir_bit` shows bit 1 of the final opcode byte (0 = reg field is the source).
- R3: The mode byte is split into mod (bits 7:6), reg (bits 5:3) and r/m (bits 2:0). When mod = 11 there is no displacement, so 88h C3h gives length 2 with reg = 000 and r/m = 011.
- R4: The 16-bit addressing rules are as follows. mod = 01 carries 1 displacement byte, which is sign-extended to 16 bits with the upper 16 bits zero. mod = 10 carries 2 bytes. mod = 00 with r/m = 110 carries 2 bytes, and mod = 00 with any other r/m carries none. No SIB byte is ever taken.
- R5: With 32-bit addressing, an SIB byte follows only when mod != 11 and r/m = 100. It is split into scale (7:6), index (5:3) and base (2:0). When there is no SIB byte, `sib_present` and the SIB fields read zero.
- R6: The 32-bit displacement rules are as follows. mod = 01 carries 1 byte, sign-extended to 32 bits. mod = 10 carries 4 bytes. mod = 00 carries 4 bytes when r/m = 101, or when an SIB byte has base = 101. mod = 00 with r/m = 110 carries none.
- R7: Displacement bytes arrive least significant first. 01h 81h 34h 12h with 16-bit addressing gives mod = 10, r/m = 001, displacement 00001234h and length 4.
- R8: Opcodes 100000sw carry an immediate; all others carry none, and an absent immediate reads zero.
  - w = 0: one byte, zero-extended.
  - w = 1, s = 0: 2 or 4 bytes, per the operand size.
  - w = 1, s = 1: one byte, sign-extended to the operand size, with the bits above it zero.
- R9: A first byte of 0Fh sets `esc`. The next byte becomes the opcode, a mode byte follows, and the length counts both opcode bytes.
- R10: `ins_len` equals the count of opcode, mode, SIB, displacement and immediate bytes. `done` is high for exactly one cycle per instruction, in the cycle after the final byte is taken.
- R11: A beat with `in_valid` low changes nothing. Idle gaps inside an instruction do not change the decoded result.
- R12: `addr32` and `opnd32` are sampled only with the first opcode byte. Changing them later in the same instruction has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Byte beat valid |
| in_byte | input | 8 | Instruction byte |
| addr32 | input | 1 | 1 = 32-bit addressing rules |
| opnd32 | input | 1 | 1 = 32-bit full operand size |
| done | output | 1 | One-cycle completion pulse |
| ins_len | output | 4 | Total instruction bytes |
| esc | output | 1 | Escape byte was seen |
| opcode | output | 8 | Final opcode byte |
| dir_bit | output | 1 | Direction bit |
| wide_bit | output | 1 | Width bit |
| mod_f | output | 2 | mod field |
| reg_f | output | 3 | reg field |
| rm_f | output | 3 | r/m field |
| sib_present | output | 1 | SIB byte was taken |
| scale_f | output | 2 | SIB scale |
| index_f | output | 3 | SIB index |
| base_f | output | 3 | SIB base |
| disp_bytes | output | 3 | Displacement byte count |
| disp_val | output | 32 | Displacement, extended per R4/R6 |
| imm_bytes | output | 3 | Immediate byte count |
| imm_val | output | 32 | Immediate, extended per R8 |

## Verification
Two things can fall in the same cycle: the `done` pulse of one instruction and the taking of the next instruction's opcode byte. At that clock edge the capture registers and the little-endian accumulators are cleared. The bench provokes this by streaming instructions back to back with no idle beat, so every pulse has a new opcode byte under it. The scoreboard then checks that each pulse still shows the fields of the instruction that just ended. It also checks that no pulse is lost and that no two pulses are adjacent.

// File: rtl/mrd_pkg.sv
package mrd_pkg;

    typedef enum logic [2:0] {
        ST_OPC,
        ST_OPC2,
        ST_MODRM,
        ST_SIB,
        ST_DISP,
        ST_IMM
    } mrd_state_e;

    localparam logic [7:0] ESC_BYTE    = 8'h0F;
    localparam int         FIELD_BYTES = 4;

    // Immediate byte count for the supported subset (group 100000sw only).
    function automatic logic [2:0] imm_size(input logic [7:0] opc, input logic o32);
        if (opc[7:2] != 6'b100000) return 3'd0;
        if (!opc[0])               return 3'd1;
        if (opc[1])                return 3'd1;
        return o32 ? 3'd4 : 3'd2;
    endfunction

    // Where to go once the addressing bytes are settled.
    function automatic mrd_state_e after_addr(input logic [2:0] dn, input logic [2:0] inn);
        if (dn != 3'd0)  return ST_DISP;
        if (inn != 3'd0) return ST_IMM;
        return ST_OPC;
    endfunction

endpackage

// File: rtl/mrd_addr_sizer.sv
module mrd_addr_sizer (
    input  logic       a32,
    input  logic [1:0] mode,
    input  logic [2:0] rm,
    input  logic [2:0] sib_base,
    output logic       need_sib,
    output logic [2:0] disp_n
);
    always_comb begin
        need_sib = a32 && (mode != 2'b11) && (rm == 3'b100);
        unique case (mode)
            2'b00: begin
                if (a32)
                    disp_n = ((rm == 3'b101) || (rm == 3'b100 && sib_base == 3'b101)) ? 3'd4 : 3'd0;
                else
                    disp_n = (rm == 3'b110) ? 3'd2 : 3'd0;
            end
            2'b01:   disp_n = 3'd1;
            2'b10:   disp_n = a32 ? 3'd4 : 3'd2;
            default: disp_n = 3'd0;
        endcase
    end
endmodule

// File: rtl/mrd_le_accum.sv
module mrd_le_accum #(
    parameter int NB = 4,
    localparam int CW = $clog2(NB + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            push,
    input  logic [7:0]      din,
    output logic [8*NB-1:0] val,
    output logic [CW-1:0]   cnt
);
    always_ff @(posedge clk) begin
        if (!rst_n || clr) cnt <= '0;
        else if (push)     cnt <= cnt + 1'b1;
    end

    for (genvar g = 0; g < NB; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (!rst_n || clr)                 val[8*g +: 8] <= 8'h00;
            else if (push && cnt == CW'(g))    val[8*g +: 8] <= din;
        end
    end

    // R7: each pushed byte advances the lane pointer by one
    p_lane_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !clr) |=> (cnt == $past(cnt) + 1'b1));

    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0));
endmodule

// File: rtl/mrd_modrm_decoder.sv
module mrd_modrm_decoder
    import mrd_pkg::*;
#(
    parameter int LEN_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [7:0]       in_byte,
    input  logic             addr32,
    input  logic             opnd32,
    output logic             done,
    output logic [LEN_W-1:0] ins_len,
    output logic             esc,
    output logic [7:0]       opcode,
    output logic             dir_bit,
    output logic             wide_bit,
    output logic [1:0]       mod_f,
    output logic [2:0]       reg_f,
    output logic [2:0]       rm_f,
    output logic             sib_present,
    output logic [1:0]       scale_f,
    output logic [2:0]       index_f,
    output logic [2:0]       base_f,
    output logic [2:0]       disp_bytes,
    output logic [31:0]      disp_val,
    output logic [2:0]       imm_bytes,
    output logic [31:0]      imm_val
);
    localparam int FW = 8 * FIELD_BYTES;
    localparam int CW = $clog2(FIELD_BYTES + 1);

    mrd_state_e       state_q, state_d;
    logic             fin;
    logic             a32_q, o32_q, esc_q, sib_q, done_q;
    logic [7:0]       opc_q;
    logic [1:0]       mod_q, scale_q;
    logic [2:0]       reg_q, rm_q, index_q, base_q, dn_q, in_q;
    logic [LEN_W-1:0] len_q;

    logic [1:0] sz_mod;
    logic [2:0] sz_rm;
    logic       sz_sib;
    logic [2:0] sz_disp;

    logic          acc_clr, d_push, i_push;
    logic [FW-1:0] d_raw, i_raw;
    logic [CW-1:0] d_cnt, i_cnt;

    assign sz_mod  = (state_q == ST_SIB) ? mod_q : in_byte[7:6];
    assign sz_rm   = (state_q == ST_SIB) ? rm_q  : in_byte[2:0];

    mrd_addr_sizer u_sizer (
        .a32      (a32_q),
        .mode     (sz_mod),
        .rm       (sz_rm),
        .sib_base (in_byte[2:0]),
        .need_sib (sz_sib),
        .disp_n   (sz_disp)
    );

    assign acc_clr = in_valid && (state_q == ST_OPC);
    assign d_push  = in_valid && (state_q == ST_DISP);
    assign i_push  = in_valid && (state_q == ST_IMM);

    mrd_le_accum #(.NB(FIELD_BYTES)) u_disp_acc (
        .clk(clk), .rst_n(rst_n), .clr(acc_clr), .push(d_push),
        .din(in_byte), .val(d_raw), .cnt(d_cnt)
    );

    mrd_le_accum #(.NB(FIELD_BYTES)) u_imm_acc (
        .clk(clk), .rst_n(rst_n), .clr(acc_clr), .push(i_push),
        .din(in_byte), .val(i_raw), .cnt(i_cnt)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        fin     = 1'b0;
        if (in_valid) begin
            unique case (state_q)
                ST_OPC:   state_d = (in_byte == ESC_BYTE) ? ST_OPC2 : ST_MODRM;
                ST_OPC2:  state_d = ST_MODRM;
                ST_MODRM: state_d = sz_sib ? ST_SIB : after_addr(sz_disp, in_q);
                ST_SIB:   state_d = after_addr(sz_disp, in_q);
                ST_DISP:  if (CW'(d_cnt) == CW'(dn_q - 3'd1)) state_d = after_addr(3'd0, in_q);
                ST_IMM:   if (CW'(i_cnt) == CW'(in_q - 3'd1)) state_d = ST_OPC;
                default:  state_d = ST_OPC;
            endcase
            fin = (state_q != ST_OPC) && (state_d == ST_OPC);
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_OPC;
        else        state_q <= state_d;
    end

    // Field capture and outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a32_q <= 1'b0; o32_q <= 1'b0; esc_q <= 1'b0; sib_q <= 1'b0;
            opc_q <= 8'h00; mod_q <= 2'b00; reg_q <= 3'd0; rm_q <= 3'd0;
            scale_q <= 2'b00; index_q <= 3'd0; base_q <= 3'd0;
            dn_q <= 3'd0; in_q <= 3'd0; len_q <= '0; done_q <= 1'b0;
        end else begin
            done_q <= fin;
            if (in_valid) begin
                unique case (state_q)
                    ST_OPC: begin
                        opc_q   <= in_byte;
                        esc_q   <= (in_byte == ESC_BYTE);
                        a32_q   <= addr32;
                        o32_q   <= opnd32;
                        in_q    <= imm_size(in_byte, opnd32);
                        len_q   <= LEN_W'(1);
                        sib_q   <= 1'b0; scale_q <= 2'b00; index_q <= 3'd0; base_q <= 3'd0;
                        mod_q   <= 2'b00; reg_q <= 3'd0; rm_q <= 3'd0; dn_q <= 3'd0;
                    end
                    ST_OPC2: begin
                        opc_q <= in_byte;
                        len_q <= len_q + 1'b1;
                    end
                    ST_MODRM: begin
                        mod_q <= in_byte[7:6];
                        reg_q <= in_byte[5:3];
                        rm_q  <= in_byte[2:0];
                        sib_q <= sz_sib;
                        dn_q  <= sz_sib ? 3'd0 : sz_disp;
                        len_q <= len_q + 1'b1;
                    end
                    ST_SIB: begin
                        scale_q <= in_byte[7:6];
                        index_q <= in_byte[5:3];
                        base_q  <= in_byte[2:0];
                        dn_q    <= sz_disp;
                        len_q   <= len_q + 1'b1;
                    end
                    default: len_q <= len_q + 1'b1;
                endcase
            end
        end
    end

    // Extension of the collected fields
    always_comb begin
        if (dn_q == 3'd1)
            disp_val = a32_q ? {{24{d_raw[7]}}, d_raw[7:0]} : {16'h0000, {8{d_raw[7]}}, d_raw[7:0]};
        else
            disp_val = d_raw[31:0];
        if (in_q == 3'd1) begin
            if (opc_q[1] && opc_q[0])
                imm_val = o32_q ? {{24{i_raw[7]}}, i_raw[7:0]} : {16'h0000, {8{i_raw[7]}}, i_raw[7:0]};
            else
                imm_val = {24'h000000, i_raw[7:0]};
        end else begin
            imm_val = i_raw[31:0];
        end
    end

    assign done        = done_q;
    assign ins_len     = len_q;
    assign esc         = esc_q;
    assign opcode      = opc_q;
    assign dir_bit     = opc_q[1];
    assign wide_bit    = opc_q[0];
    assign mod_f       = mod_q;
    assign reg_f       = reg_q;
    assign rm_f        = rm_q;
    assign sib_present = sib_q;
    assign scale_f     = scale_q;
    assign index_f     = index_q;
    assign base_f      = base_q;
    assign disp_bytes  = dn_q;
    assign imm_bytes   = in_q;

    // R10: completion pulse lasts one cycle
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

    // R10: reported length matches the byte counts of each part
    p_len_sum_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (len_q == LEN_W'(2) + LEN_W'(esc_q) + LEN_W'(sib_q) + LEN_W'(dn_q) + LEN_W'(in_q)));

    // R11: idle beats leave the controller untouched
    p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(state_q) && $stable(len_q)));

    // R4: 16-bit addressing never yields SIB or more than two displacement bytes
    p_disp16_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && !a32_q) |-> (dn_q <= 3'd2 && !sib_q));

    // R12: size selects move only with an opcode byte
    p_mode_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && state_q == ST_OPC) |=> ($stable(a32_q) && $stable(o32_q)));

    // R9: escaped opcodes carry no immediate
    p_esc_noimm_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && esc_q) |-> (in_q == 3'd0 && len_q >= LEN_W'(3)));
endmodule

// File: tb/sim_mrd_modrm_decoder.sv
module sim_mrd_modrm_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = 8'h00;
    logic        addr32 = 1'b0;
    logic        opnd32 = 1'b0;
    logic        done, esc, dir_bit, wide_bit, sib_present;
    logic [3:0]  ins_len;
    logic [7:0]  opcode;
    logic [1:0]  mod_f, scale_f;
    logic [2:0]  reg_f, rm_f, index_f, base_f, disp_bytes, imm_bytes;
    logic [31:0] disp_val, imm_val;

    always #5 clk = ~clk;

    mrd_modrm_decoder u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .addr32(addr32), .opnd32(opnd32), .done(done), .ins_len(ins_len),
        .esc(esc), .opcode(opcode), .dir_bit(dir_bit), .wide_bit(wide_bit),
        .mod_f(mod_f), .reg_f(reg_f), .rm_f(rm_f), .sib_present(sib_present),
        .scale_f(scale_f), .index_f(index_f), .base_f(base_f),
        .disp_bytes(disp_bytes), .disp_val(disp_val),
        .imm_bytes(imm_bytes), .imm_val(imm_val)
    );

    typedef struct {
        string       tag;
        int          len;
        bit          esc;
        logic [7:0]  opc;
        logic [7:0]  mrm;
        bit          sib;
        logic [7:0]  sibb;
        int          dn;
        logic [31:0] dv;
        int          inn;
        logic [31:0] iv;
    } exp_t;

    exp_t       exp_q[$];
    logic [7:0] bq[$];
    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;
    bit prev_done = 1'b0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
        end
    endtask

    task automatic b(input logic [7:0] v);
        bq.push_back(v);
    endtask

    task automatic expect_item(input string tag, input int len, input bit e, input logic [7:0] opc,
                               input logic [7:0] mrm, input bit sib, input logic [7:0] sibb,
                               input int dn, input logic [31:0] dv, input int inn, input logic [31:0] iv);
        exp_t x;
        x.tag = tag; x.len = len; x.esc = e; x.opc = opc; x.mrm = mrm;
        x.sib = sib; x.sibb = sib ? sibb : 8'h00;
        x.dn = dn; x.dv = dv; x.inn = inn; x.iv = iv;
        exp_q.push_back(x);
    endtask

    // Drive the queued bytes; flip inverts the size selects after the first byte.
    task automatic issue(input bit a32, input bit o32, input int gap, input bit flip);
        bit first = 1'b1;
        while (bq.size() > 0) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_byte  = bq.pop_front();
            addr32   = (first || !flip) ? a32 : ~a32;
            opnd32   = (first || !flip) ? o32 : ~o32;
            first    = 1'b0;
            for (int k = 0; k < gap; k++) begin
                if (bq.size() > 0) begin
                    @(negedge clk);
                    in_valid = 1'b0;
                    in_byte  = 8'hFF;
                end
            end
        end
    endtask

    // Monitor: pops an expected item on each completion pulse.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (done && prev_done)
                    chk(1'b0, "R10", "adjacent done pulses", 32'd1, 32'd0);
                if (done) begin
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R10", "unexpected done", 32'd1, 32'd0);
                    end else begin
                        exp_t e;
                        e = exp_q.pop_front();
                        chk(ins_len == 4'(e.len), e.tag, "length", 32'(ins_len), 32'(e.len));
                        chk(esc == e.esc, e.tag, "esc", 32'(esc), 32'(e.esc));
                        chk(opcode == e.opc, e.tag, "opcode", 32'(opcode), 32'(e.opc));
                        chk(dir_bit == e.opc[1], "R2", "dir_bit", 32'(dir_bit), 32'(e.opc[1]));
                        chk(wide_bit == e.opc[0], "R2", "wide_bit", 32'(wide_bit), 32'(e.opc[0]));
                        chk(mod_f == e.mrm[7:6], e.tag, "mod", 32'(mod_f), 32'(e.mrm[7:6]));
                        chk(reg_f == e.mrm[5:3], e.tag, "reg", 32'(reg_f), 32'(e.mrm[5:3]));
                        chk(rm_f == e.mrm[2:0], e.tag, "rm", 32'(rm_f), 32'(e.mrm[2:0]));
                        chk(sib_present == e.sib, e.tag, "sib_present", 32'(sib_present), 32'(e.sib));
                        chk({scale_f, index_f, base_f} == e.sibb, e.tag, "sib fields",
                            32'({scale_f, index_f, base_f}), 32'(e.sibb));
                        chk(disp_bytes == 3'(e.dn), e.tag, "disp_bytes", 32'(disp_bytes), 32'(e.dn));
                        chk(disp_val == e.dv, e.tag, "disp_val", disp_val, e.dv);
                        chk(imm_bytes == 3'(e.inn), e.tag, "imm_bytes", 32'(imm_bytes), 32'(e.inn));
                        chk(imm_val == e.iv, e.tag, "imm_val", imm_val, e.iv);
                    end
                end
            end
            prev_done = done;
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(done == 1'b0, "R1", "done after reset", 32'(done), 32'd0);
        chk(ins_len == 4'd0, "R1", "length after reset", 32'(ins_len), 32'd0);
        chk(disp_bytes == 3'd0 && imm_bytes == 3'd0, "R1", "field counts after reset",
            32'({disp_bytes, imm_bytes}), 32'd0);

        // R3 register form, 16-bit
        expect_item("R3", 2, 0, 8'h88, 8'hC3, 0, 8'h00, 0, 32'h0, 0, 32'h0);
        b(8'h88); b(8'hC3); issue(0, 0, 0, 0);
        // R7 little-endian 16-bit displacement
        expect_item("R7", 4, 0, 8'h01, 8'h81, 0, 8'h00, 2, 32'h00001234, 0, 32'h0);
        b(8'h01); b(8'h81); b(8'h34); b(8'h12); issue(0, 0, 0, 0);
        // R4 mod=01 sign extension to 16 bits
        expect_item("R4", 3, 0, 8'h8B, 8'h46, 0, 8'h00, 1, 32'h0000FFF0, 0, 32'h0);
        b(8'h8B); b(8'h46); b(8'hF0); issue(0, 0, 0, 0);
        // R4 direct 16-bit address
        expect_item("R4", 4, 0, 8'h03, 8'h06, 0, 8'h00, 2, 32'h00005678, 0, 32'h0);
        b(8'h03); b(8'h06); b(8'h78); b(8'h56); issue(0, 0, 0, 0);
        // R4 no SIB in 16-bit mode even with r/m=100
        expect_item("R4", 2, 0, 8'h8B, 8'h04, 0, 8'h00, 0, 32'h0, 0, 32'h0);
        b(8'h8B); b(8'h04); issue(0, 0, 0, 0);
        // R6 mod=00 r/m=110 in 32-bit: no displacement
        expect_item("R6", 2, 0, 8'h03, 8'h06, 0, 8'h00, 0, 32'h0, 0, 32'h0);
        b(8'h03); b(8'h06); issue(1, 0, 0, 0);
        // R5 SIB ends the instruction
        expect_item("R5", 3, 0, 8'h8B, 8'h04, 1, 8'h88, 0, 32'h0, 0, 32'h0);
        b(8'h8B); b(8'h04); b(8'h88); issue(1, 0, 0, 0);
        // R5 mod=11 with r/m=100 takes no SIB
        expect_item("R5", 2, 0, 8'h8B, 8'hC4, 0, 8'h00, 0, 32'h0, 0, 32'h0);
        b(8'h8B); b(8'hC4); issue(1, 0, 0, 0);
        // R6 direct 32-bit address
        expect_item("R6", 6, 0, 8'h8B, 8'h05, 0, 8'h00, 4, 32'h12345678, 0, 32'h0);
        b(8'h8B); b(8'h05); b(8'h78); b(8'h56); b(8'h34); b(8'h12); issue(1, 0, 0, 0);
        // R6 SIB base=101 with mod=00
        expect_item("R6", 7, 0, 8'h8B, 8'h04, 1, 8'h8D, 4, 32'h11223344, 0, 32'h0);
        b(8'h8B); b(8'h04); b(8'h8D); b(8'h44); b(8'h33); b(8'h22); b(8'h11); issue(1, 0, 0, 0);
        // R6 SIB with 8-bit displacement sign-extended to 32 bits
        expect_item("R6", 4, 0, 8'h8B, 8'h44, 1, 8'h24, 1, 32'hFFFFFF80, 0, 32'h0);
        b(8'h8B); b(8'h44); b(8'h24); b(8'h80); issue(1, 0, 0, 0);
        // R6 mod=10 in 32-bit takes four bytes
        expect_item("R6", 6, 0, 8'h01, 8'h81, 0, 8'h00, 4, 32'h00001234, 0, 32'h0);
        b(8'h01); b(8'h81); b(8'h34); b(8'h12); b(8'h00); b(8'h00); issue(1, 0, 0, 0);
        // R8 immediates
        expect_item("R8", 3, 0, 8'h80, 8'hC1, 0, 8'h00, 0, 32'h0, 1, 32'h000000AB);
        b(8'h80); b(8'hC1); b(8'hAB); issue(0, 0, 0, 0);
        expect_item("R8", 3, 0, 8'h82, 8'hC1, 0, 8'h00, 0, 32'h0, 1, 32'h000000F0);
        b(8'h82); b(8'hC1); b(8'hF0); issue(0, 1, 0, 0);
        expect_item("R8", 4, 0, 8'h81, 8'hC1, 0, 8'h00, 0, 32'h0, 2, 32'h00001234);
        b(8'h81); b(8'hC1); b(8'h34); b(8'h12); issue(0, 0, 0, 0);
        expect_item("R8", 6, 0, 8'h81, 8'hC1, 0, 8'h00, 0, 32'h0, 4, 32'h12345678);
        b(8'h81); b(8'hC1); b(8'h78); b(8'h56); b(8'h34); b(8'h12); issue(0, 1, 0, 0);
        expect_item("R8", 3, 0, 8'h83, 8'hC1, 0, 8'h00, 0, 32'h0, 1, 32'h0000FFF0);
        b(8'h83); b(8'hC1); b(8'hF0); issue(0, 0, 0, 0);
        expect_item("R8", 3, 0, 8'h83, 8'hC1, 0, 8'h00, 0, 32'h0, 1, 32'hFFFFFFF0);
        b(8'h83); b(8'hC1); b(8'hF0); issue(0, 1, 0, 0);
        expect_item("R8", 3, 0, 8'h83, 8'hC1, 0, 8'h00, 0, 32'h0, 1, 32'h00000005);
        b(8'h83); b(8'hC1); b(8'h05); issue(0, 1, 0, 0);
        // R10 longest form: SIB, 4-byte displacement, 4-byte immediate
        expect_item("R10", 11, 0, 8'h81, 8'h84, 1, 8'h88, 4, 32'h12345678, 4, 32'hDEADBEEF);
        b(8'h81); b(8'h84); b(8'h88); b(8'h78); b(8'h56); b(8'h34); b(8'h12);
        b(8'hEF); b(8'hBE); b(8'hAD); b(8'hDE); issue(1, 1, 0, 0);
        // R9 escape
        expect_item("R9", 3, 1, 8'hAF, 8'hC3, 0, 8'h00, 0, 32'h0, 0, 32'h0);
        b(8'h0F); b(8'hAF); b(8'hC3); issue(0, 0, 0, 0);
        expect_item("R9", 4, 1, 8'hB6, 8'h46, 0, 8'h00, 1, 32'h00000010, 0, 32'h0);
        b(8'h0F); b(8'hB6); b(8'h46); b(8'h10); issue(0, 0, 0, 0);
        // R11 idle gaps inside an instruction
        expect_item("R11", 4, 0, 8'h01, 8'h81, 0, 8'h00, 2, 32'h00001234, 0, 32'h0);
        b(8'h01); b(8'h81); b(8'h34); b(8'h12); issue(0, 0, 3, 0);
        // R12 size selects changed after the opcode byte
        expect_item("R12", 4, 0, 8'h8B, 8'h86, 0, 8'h00, 2, 32'h00001234, 0, 32'h0);
        b(8'h8B); b(8'h86); b(8'h34); b(8'h12); issue(0, 0, 0, 1);
        expect_item("R12", 4, 0, 8'h81, 8'hC1, 0, 8'h00, 0, 32'h0, 2, 32'h00001234);
        b(8'h81); b(8'hC1); b(8'h34); b(8'h12); issue(0, 0, 1, 1);

        @(negedge clk);
        in_valid = 1'b0;
        repeat (5) @(negedge clk);
        // R10 every instruction produced its pulse
        chk(exp_q.size() == 0, "R10", "missing done pulses", 32'(exp_q.size()), 32'd0);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule